// File: doc/BRIEF.md
# DRAM Data-Pin Output Control Model

This block models the data-pin output path of a four-bit-wide fast-page-mode DRAM. It serves as the device side of a memory-controller test bench. A free-running model clock samples the four active-low strobes: row strobe, column strobe, write enable and output enable. Edges are found by comparing each strobe with its value in the previous cycle. The block also takes the four bits read from the addressed cell. From these it decides which cycle type is in progress, and whether read data is still held in its output latch.

The data pins are driven only while the column strobe and output enable are both low and the latch holds valid read data. The latch is loaded when the column strobe falls with the row strobe low and write enable high. It survives changes of output enable, a write that follows the read, and a refresh hidden under a held-low column strobe. Two events clear it: the column strobe staying high for `CPN_CYC` consecutive clock cycles, or an early write. All pins are plain levels. There is no stream interface, so no back-pressure rules apply.

Top module: `dram_dq_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after, `dq_oe`=0, `dq_out`=0, `cyc_kind`=0 and `proto_err`=0. Any data latched before reset is discarded: a later column-strobe low with output enable low drives nothing.
- R2: Outputs register the strobes sampled at a clock edge. If the column strobe was high at an edge, `dq_oe` is 0 after that edge.
- R3: A column-strobe fall with the row strobe low and write enable high latches `cell_rd` and sets `cyc_kind`=1 (read). The latched value is driven (`dq_oe`=1) while output enable is low.
- R4: In a read, output enable going high turns `dq_oe` off. If output enable returns low while the column strobe is still low, the same latched value is driven again, even if `cell_rd` has changed.
- R5: After the column strobe has been high for `CPN_CYC` (default 2) consecutive cycles, the latch is invalid and output enable is ignored. If the high time is shorter, taking the column strobe low again with output enable low re-drives the old data.
- R6: A column-strobe fall with write enable low and the row strobe low sets `cyc_kind`=2 (early write) and invalidates the latch. `dq_oe` stays 0 throughout that cycle.
- R7: In a read cycle, a write-enable fall with the column strobe low sets `cyc_kind`=4 (read-modify-write) if output enable was low at some time since the column strobe fell. Otherwise it sets `cyc_kind`=3 (late write).
- R8: After a late write or read-modify-write, output enable going low while the column strobe is still low drives the data latched at the column-strobe fall.
- R9: A row-strobe fall while the column strobe is low sets `cyc_kind`=5 (refresh) and keeps the latch. A row-strobe fall with the column strobe high sets `cyc_kind`=0. With both strobes high, `cyc_kind`=0.
- R10: `proto_err` pulses for one cycle when write enable falls while the column strobe was already low and output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | model clock |
| rst_n | input | 1 | active-low synchronous reset |
| ras_n | input | 1 | row strobe, active low |
| cas_n | input | 1 | column strobe, active low |
| we_n | input | 1 | write enable, active low |
| oe_n | input | 1 | output enable, active low |
| cell_rd | input | DQ_W | data read from the addressed cell |
| dq_out | output | DQ_W | latched data presented on the pins |
| dq_oe | output | 1 | pins driven (0 means high impedance) |
| cyc_kind | output | 3 | 0 idle, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 refresh |
| proto_err | output | 1 | write-enable fall with output enable low after column strobe low |

## Verification
The strobe sequences are a plain read, a read with output enable toggled, an early write, a late write with output enable high throughout, a read-modify-write, and a hidden refresh under a held column strobe. Together they separate the three ways a write can be classified, and they show whether the latch survives each kind of strobe change. The column-strobe high time is tried just below and at `CPN_CYC`. This exposes an off-by-one in the latch-clear count. A changed `cell_rd` during the re-drive steps shows whether the data comes from the latch or leaks straight through from the cell.

// File: rtl/dqc_pkg.sv
package dqc_pkg;
  typedef enum logic [2:0] {
    CK_IDLE = 3'd0,
    CK_READ = 3'd1,
    CK_EWR  = 3'd2,
    CK_LWR  = 3'd3,
    CK_RMW  = 3'd4,
    CK_REF  = 3'd5
  } cyc_kind_e;

  localparam int unsigned SI_RAS   = 0;
  localparam int unsigned SI_CAS   = 1;
  localparam int unsigned SI_WE    = 2;
  localparam int unsigned N_EDGED  = 3;
endpackage

// File: rtl/dqc_strobe_edge.sv
module dqc_strobe_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_edge
    // strobes idle high, so reset to high avoids a false fall
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b1;
      else        prev_q[g] <= lvl[g];
    end
    assign fall[g] = prev_q[g] & ~lvl[g];
  end
endmodule

// File: rtl/dqc_cycle_tracker.sv
module dqc_cycle_tracker
  import dqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  input  logic      oe_n,
  input  logic      ras_fall,
  input  logic      cas_fall,
  input  logic      we_fall,
  output cyc_kind_e kind,
  output logic      proto_err
);
  cyc_kind_e kind_q, kind_d;
  logic      oe_seen_q, oe_seen_d;
  logic      err_q, err_d;
  logic      cas_was_low;

  // column strobe low now and not a fresh fall => it was low last cycle
  assign cas_was_low = ~cas_n & ~cas_fall;

  always_comb begin
    kind_d = kind_q;
    if (ras_fall) begin
      kind_d = cas_n ? CK_IDLE : CK_REF;
    end else if (ras_n && cas_n) begin
      kind_d = CK_IDLE;
    end else if (cas_fall && !ras_n) begin
      kind_d = we_n ? CK_READ : CK_EWR;
    end else if (we_fall && !cas_n && !ras_n && kind_q == CK_READ) begin
      kind_d = oe_seen_q ? CK_RMW : CK_LWR;
    end
  end

  always_comb begin
    oe_seen_d = oe_seen_q;
    if (cas_fall)                oe_seen_d = ~oe_n;
    else if (!cas_n && !oe_n)    oe_seen_d = 1'b1;
  end

  assign err_d = we_fall & cas_was_low & ~oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q    <= CK_IDLE;
      oe_seen_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      kind_q    <= kind_d;
      oe_seen_q <= oe_seen_d;
      err_q     <= err_d;
    end
  end

  assign kind      = kind_q;
  assign proto_err = err_q;

  // R10: the error flag is a single-cycle pulse
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);

  // R9: both strobes high at an edge leaves the tracker idle
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n) |=> (kind == CK_IDLE));
endmodule

// File: rtl/dqc_out_latch.sv
module dqc_out_latch #(
  parameter int unsigned DQ_W    = 4,
  parameter int unsigned CPN_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic            cas_fall,
  input  logic [DQ_W-1:0] cell_rd,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe
);
  localparam int unsigned CW = (CPN_CYC < 2) ? 1 : $clog2(CPN_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CPN_CYC - 1);

  logic            held_q, held_d;
  logic [DQ_W-1:0] data_q, data_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            oe_q, oe_d;

  always_comb begin
    held_d = held_q;
    data_d = data_q;
    cnt_d  = cnt_q;
    if (!cas_n) cnt_d = '0;
    if (cas_fall && !ras_n) begin
      if (we_n) begin
        held_d = 1'b1;
        data_d = cell_rd;
      end else begin
        held_d = 1'b0;
      end
    end else if (cas_n) begin
      if (cnt_q >= CNT_LAST) held_d = 1'b0;
      else                   cnt_d  = cnt_q + 1'b1;
    end
    oe_d = ~cas_n & ~oe_n & held_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      data_q <= '0;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      held_q <= held_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
      oe_q   <= oe_d;
    end
  end

  assign dq_out = data_q;
  assign dq_oe  = oe_q;

  // R2: a high column strobe at an edge forces high impedance after it
  assert_hiz_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !dq_oe);

  // R4: while pins stay driven, the presented data does not change
  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |=> (!dq_oe || $stable(dq_out)));

  // R4: pins are only driven when output enable was low
  assert_oe_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !$past(oe_n));
endmodule

// File: rtl/dram_dq_ctrl.sv
module dram_dq_ctrl
  import dqc_pkg::*;
#(
  parameter int unsigned DQ_W    = 4,
  parameter int unsigned CPN_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [DQ_W-1:0] cell_rd,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe,
  output logic [2:0]      cyc_kind,
  output logic            proto_err
);
  logic [N_EDGED-1:0] sb_lvl;
  logic [N_EDGED-1:0] sb_fall;
  cyc_kind_e          kind;

  assign sb_lvl[SI_RAS] = ras_n;
  assign sb_lvl[SI_CAS] = cas_n;
  assign sb_lvl[SI_WE]  = we_n;

  dqc_strobe_edge #(.N(N_EDGED)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (sb_lvl),
    .fall (sb_fall)
  );

  dqc_cycle_tracker u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .ras_fall (sb_fall[SI_RAS]),
    .cas_fall (sb_fall[SI_CAS]),
    .we_fall  (sb_fall[SI_WE]),
    .kind     (kind),
    .proto_err(proto_err)
  );

  dqc_out_latch #(.DQ_W(DQ_W), .CPN_CYC(CPN_CYC)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .cas_fall(sb_fall[SI_CAS]),
    .cell_rd (cell_rd),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

  assign cyc_kind = kind;

  // R6: an early-write cycle never drives the pins
  assert_early_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_EWR) |-> !dq_oe);
endmodule

// File: tb/dram_dq_ctrl_bench.sv
`timescale 1ns/1ps
module dram_dq_ctrl_bench;
  localparam int DQ_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [DQ_W-1:0] cell_rd = '0;
  logic [DQ_W-1:0] dq_out;
  logic            dq_oe;
  logic [2:0]      cyc_kind;
  logic            proto_err;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dram_dq_ctrl #(.DQ_W(DQ_W), .CPN_CYC(2)) u_dram_dq_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .cell_rd(cell_rd), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_kind(cyc_kind), .proto_err(proto_err)
  );

  typedef struct packed {
    logic       ras, cas, we, oe;
    logic [3:0] rd;
    logic       eoe;
    logic [3:0] edq;
    logic [2:0] ek;
    logic       eerr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 44;
  // kinds: 0 idle, 1 read, 2 early write, 3 late write, 4 rmw, 5 refresh
  localparam vec_t TBL [NV] = '{
    // plain read, OE toggle (R3, R4), CAS rise then OE ignored (R5)
    '{1,1,1,1,4'h0, 0,4'h0,3'd0,0, 4'd2},  // R2 idle
    '{0,1,1,1,4'hA, 0,4'h0,3'd0,0, 4'd9},  // R9 row fall, col high
    '{0,0,1,0,4'hA, 1,4'hA,3'd1,0, 4'd3},  // R3 latch A, drive
    '{0,0,1,1,4'h5, 0,4'h0,3'd1,0, 4'd4},  // R4 OE high
    '{0,0,1,0,4'h5, 1,4'hA,3'd1,0, 4'd4},  // R4 redrive A
    '{0,1,1,0,4'h5, 0,4'h0,3'd1,0, 4'd2},  // R2 col high
    '{0,1,1,1,4'h5, 0,4'h0,3'd1,0, 4'd5},  // R5
    '{1,1,1,0,4'h5, 0,4'h0,3'd0,0, 4'd5},  // R5 OE ignored
    '{1,0,1,0,4'hC, 0,4'h0,3'd0,0, 4'd5},  // R5 latch expired
    '{0,0,1,0,4'hC, 0,4'h0,3'd5,0, 4'd9},  // R9 refresh, nothing held
    '{1,1,1,1,4'hC, 0,4'h0,3'd0,0, 4'd9},  // R9 idle
    // hidden refresh after read (R9)
    '{0,1,1,1,4'hB, 0,4'h0,3'd0,0, 4'd9},
    '{0,0,1,0,4'hB, 1,4'hB,3'd1,0, 4'd3},  // R3
    '{1,0,1,0,4'hB, 1,4'hB,3'd1,0, 4'd9},  // R9 row rises, col low
    '{0,0,1,0,4'h7, 1,4'hB,3'd5,0, 4'd9},  // R9 refresh keeps B
    '{0,0,1,1,4'h7, 0,4'h0,3'd5,0, 4'd9},  // R9 OE high quiet
    '{1,1,1,1,4'h7, 0,4'h0,3'd0,0, 4'd9},
    // short column-high gap keeps latch (R5)
    '{0,1,1,1,4'h3, 0,4'h0,3'd0,0, 4'd5},
    '{0,0,1,0,4'h3, 1,4'h3,3'd1,0, 4'd3},
    '{1,1,1,1,4'h3, 0,4'h0,3'd0,0, 4'd5},
    '{1,0,1,0,4'h9, 1,4'h3,3'd0,0, 4'd5},  // R5 one cycle high: kept
    '{1,1,1,1,4'h9, 0,4'h0,3'd0,0, 4'd5},
    '{1,1,1,1,4'h9, 0,4'h0,3'd0,0, 4'd5},
    // early write (R6)
    '{0,1,0,1,4'h6, 0,4'h0,3'd0,0, 4'd6},
    '{0,0,0,0,4'h6, 0,4'h0,3'd2,0, 4'd6},
    '{0,0,0,0,4'h6, 0,4'h0,3'd2,0, 4'd6},
    '{0,0,1,0,4'h6, 0,4'h0,3'd2,0, 4'd6},
    '{1,1,1,1,4'h6, 0,4'h0,3'd0,0, 4'd6},
    // late write, OE high throughout (R7, R8)
    '{0,1,1,1,4'hD, 0,4'h0,3'd0,0, 4'd7},
    '{0,0,1,1,4'hD, 0,4'h0,3'd1,0, 4'd7},
    '{0,0,0,1,4'hD, 0,4'h0,3'd3,0, 4'd7},
    '{0,0,1,0,4'h2, 1,4'hD,3'd3,0, 4'd8},
    '{1,1,1,1,4'h2, 0,4'h0,3'd0,0, 4'd8},
    // read-modify-write (R7, R8)
    '{0,1,1,1,4'hE, 0,4'h0,3'd0,0, 4'd7},
    '{0,0,1,0,4'hE, 1,4'hE,3'd1,0, 4'd3},
    '{0,0,1,1,4'hE, 0,4'h0,3'd1,0, 4'd7},
    '{0,0,0,1,4'hE, 0,4'h0,3'd4,0, 4'd7},
    '{0,0,0,0,4'h1, 1,4'hE,3'd4,0, 4'd8},
    '{1,1,1,1,4'h1, 0,4'h0,3'd0,0, 4'd8},
    // write-enable fall with OE low (R10)
    '{0,1,1,1,4'h2, 0,4'h0,3'd0,0, 4'd10},
    '{0,0,1,0,4'h2, 1,4'h2,3'd1,0, 4'd10},
    '{0,0,0,0,4'h2, 1,4'h2,3'd4,1, 4'd10},
    '{0,0,0,0,4'h2, 1,4'h2,3'd4,0, 4'd10},
    '{1,1,1,1,4'h2, 0,4'h0,3'd0,0, 4'd10}
  };

  task automatic check(input string tag, input logic eoe, input logic [3:0] edq,
                       input logic [2:0] ek, input logic eerr, input logic dq_chk);
    logic bad;
    checks++;
    bad = (dq_oe !== eoe) || (cyc_kind !== ek) || (proto_err !== eerr) ||
          (dq_chk && dq_out !== edq);
    if (bad) begin
      errors++;
      $display("FAIL %s: oe=%0b dq=%h kind=%0d err=%0b expected oe=%0b dq=%h kind=%0d err=%0b",
               tag, dq_oe, dq_out, cyc_kind, proto_err, eoe, edq, ek, eerr);
    end
  endtask

  task automatic drive(input logic r, input logic c, input logic w, input logic o,
                       input logic [3:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; cell_rd = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 0, 4'h0, 3'd0, 0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 0, 4'h0, 3'd0, 0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].ras, TBL[i].cas, TBL[i].we, TBL[i].oe, TBL[i].rd);
      @(negedge clk);
      check($sformatf("R%0d step %0d", TBL[i].req, i), TBL[i].eoe, TBL[i].edq,
            TBL[i].ek, TBL[i].eerr, TBL[i].eoe);
    end

    // R1: reset in the middle of a driven read discards the latch
    drive(0, 1, 1, 1, 4'h8); @(negedge clk);
    drive(0, 0, 1, 0, 4'h8); @(negedge clk);
    check("R3 pre-reset read", 1, 4'h8, 3'd1, 0, 1'b1);
    rst_n = 1'b0;
    drive(1, 1, 1, 1, 4'h8);
    @(negedge clk);
    check("R1 mid-read reset", 0, 4'h0, 3'd0, 0, 1'b1);
    rst_n = 1'b1;
    drive(1, 0, 1, 0, 4'h8);
    @(negedge clk);
    check("R1 latch discarded", 0, 4'h0, 3'd0, 0, 1'b0);
    drive(1, 1, 1, 1, 4'h0);
    @(negedge clk);
    check("R2 quiet end", 0, 4'h0, 3'd0, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule